// File: doc/BRIEF.md
# PCIe Endpoint Reset Domain Controller

This block produces the four reset outputs that an endpoint interface needs. One output clears the sticky configuration state. One clears the core (hard) logic. The other two clear the streaming data path and the control/status register responder. The domains nest:

- A platform reset asserts all four outputs.
- A warm reset or a hot reset asserts every output except the sticky one.
- The two bus outputs always move together, but each is driven by its own flop.

On release, the domains come out one at a time. The sticky domain goes first. The core domain follows a fixed number of cycles later, and both bus domains follow the same number of cycles after that.

Two rules space out the resets that arrive on the link:

- **Guard window.** Each release of the bus domains starts a guard window of about 500 µs, counted in clock cycles.
- **Deferred hot reset.** A hot reset that arrives while the guard window is open, or while a function-level reset is still busy, is held. It is applied on the first cycle on which neither condition holds.

A user warm request acts at once from the running state. The platform reset pin also initializes the controller itself. Its low level is passed through a two-flop synchronizer that clears asynchronously, so every output asserts at once and releases in step with the clock.

Top module: `pcie_reset_ctrl`

## Requirements
- R1: While `plat_rst_n_i` is low, `sticky_rst_o`, `core_rst_o`, `stream_rst_o` and `csr_rst_o` are 1 and `all_up_o` is 0. This holds without waiting for a clock edge after the pin falls.
- R2: After the platform pin is released, `sticky_rst_o` falls first. `core_rst_o` falls exactly STAGE_CYCLES cycles later, and both bus outputs fall exactly STAGE_CYCLES cycles after that.
- R3: `stream_rst_o` and `csr_rst_o` are equal in every cycle. Whenever `core_rst_o` is 1, both bus outputs are 1. Whenever `sticky_rst_o` is 1, `core_rst_o` is 1.
- R4: In the running state, a cycle with `warm_req_i` high asserts `core_rst_o` and both bus outputs on the next clock edge. This happens even while the guard window is open or `fn_rst_busy_i` is high. `sticky_rst_o` stays 0. The request may be repeated any number of times.
- R5: A one-cycle pulse on `link_hot_rst_i` while `guard_active_o` is 1 is held pending. It asserts `core_rst_o` on the clock edge after the first edge at which the guard window has closed.
- R6: A hot reset seen while `fn_rst_busy_i` is 1 is held pending. It takes effect on the first edge at which `fn_rst_busy_i` is 0 and the guard window is closed.
- R7: `guard_active_o` rises on the same edge as the bus outputs fall. It stays 1 for exactly G = CLK_FREQ_HZ × GUARD_US / 1 000 000 cycles.
- R8: `all_up_o` is 1 exactly when all four reset outputs are 0.
- R9: A warm request made while a release sequence is under way has no effect. The stage lengths of that sequence stay at STAGE_CYCLES.
- R10: A hot reset in the running state, with the guard closed and no function-level reset busy, asserts `core_rst_o` and both bus outputs on the next edge. `sticky_rst_o` stays 0. After a warm or hot reset, `core_rst_o` stays 1 for STAGE_CYCLES cycles and the bus outputs fall STAGE_CYCLES cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| plat_rst_n_i | input | 1 | Platform reset, active low, asynchronous |
| warm_req_i | input | 1 | User warm reset request, sampled each cycle |
| link_hot_rst_i | input | 1 | Hot reset indication from the link, sampled each cycle |
| fn_rst_busy_i | input | 1 | High while a function-level reset is in progress |
| sticky_rst_o | output | 1 | Cold reset for sticky configuration state, active high |
| core_rst_o | output | 1 | Core logic reset, active high |
| stream_rst_o | output | 1 | Streaming data path reset, active high |
| csr_rst_o | output | 1 | Control/status responder reset, active high |
| guard_active_o | output | 1 | Minimum-spacing window is open |
| all_up_o | output | 1 | Every domain is out of reset |

## Verification
A table of requests is replayed right after a release. Each entry chooses a warm or a hot request, whether it lands inside or outside the guard window, and how long the function-level-reset busy flag is held. The delay to the next core assertion tells the four outcomes apart:

- a warm request that bypasses both gates;
- an idle hot reset;
- a hot reset deferred by the guard;
- a hot reset deferred by the busy flag, or by the larger of the two.

Stage lengths measured on every sequence separate the staged release from one that releases too early or too late. Directed tests cover the asynchronous assertion on the pin, the exact guard length, and a warm request made during a cold release.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
// Shared types for the reset domain controller.
// Assumes: nothing beyond the standard language.
package rdc_pkg;

    // Release sequencer states, in the order a cold release walks them
    typedef enum logic [1:0] {
        SEQ_COLD = 2'd0,   // sticky, core and bus domains held
        SEQ_CORE = 2'd1,   // core and bus domains held
        SEQ_BUS  = 2'd2,   // bus domains held
        SEQ_RUN  = 2'd3    // all domains released
    } seq_state_e;

endpackage

// File: rtl/rdc_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: clears at once when the asynchronous active-low
// input falls, and releases after STAGES clock edges once it rises.
// Assumes: STAGES >= 2. This is the only asynchronously cleared logic in
// the block, because it is what turns the pin into the synchronous reset.
module rdc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic async_n_i,
    output logic sync_n_o
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain while the pin is low
    always_ff @(posedge clk_i or negedge async_n_i) begin
        if (!async_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rdc_guard.sv
`timescale 1ns/1ps
// Minimum-spacing guard: a start pulse loads GUARD_CYCLES into a down
// counter, and the window is open while the counter is non-zero.
// Assumes: GUARD_CYCLES >= 1; a start pulse while open restarts the window.
module rdc_guard #(
    parameter int unsigned GUARD_CYCLES = 100000
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic start_i,
    output logic active_o
);

    localparam int unsigned CW = $clog2(GUARD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(GUARD_CYCLES);

    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero otherwise
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/rdc_sequencer.sv
`timescale 1ns/1ps
// Release sequencer: walks the staged release after a cold reset, and
// accepts warm and hot resets from the running state.
// - Hot resets are held pending while the guard window is open or a
//   function-level reset is busy.
// - Warm requests made outside the running state are ignored.
// Reset outputs are registered from the next state.
// Assumes: rst_n_i is synchronous; STAGE_CYCLES >= 1.
module rdc_sequencer
    import rdc_pkg::*;
#(
    parameter int unsigned STAGE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic warm_req_i,
    input  logic hot_req_i,
    input  logic fn_busy_i,
    input  logic guard_active_i,
    output logic sticky_q_o,
    output logic core_q_o,
    output logic stream_q_o,
    output logic csr_q_o,
    output logic all_up_q_o,
    output logic release_o
);

    localparam int unsigned CNT_W = (STAGE_CYCLES > 1) ? $clog2(STAGE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STAGE_CYCLES - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              hot_pend_q;
    logic              stage_done, take_hot, take_warm;

    // Next-state decision and acceptance of warm and hot requests
    always_comb begin
        stage_done = (cnt_q == '0);
        take_hot   = (state_q == SEQ_RUN) && (hot_req_i || hot_pend_q)
                     && !guard_active_i && !fn_busy_i;
        take_warm  = (state_q == SEQ_RUN) && warm_req_i;
        state_d    = state_q;
        case (state_q)
            SEQ_COLD: if (stage_done) state_d = SEQ_CORE;
            SEQ_CORE: if (stage_done) state_d = SEQ_BUS;
            SEQ_BUS:  if (stage_done) state_d = SEQ_RUN;
            SEQ_RUN:  if (take_hot || take_warm) state_d = SEQ_CORE;
            default:  state_d = SEQ_COLD;
        endcase
        release_o = (state_q != SEQ_RUN) && (state_d == SEQ_RUN);
    end

    // State, stage counter and hot-reset pending flag
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q    <= SEQ_COLD;
            cnt_q      <= CNT_LOAD;
            hot_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= CNT_LOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (take_hot) begin
                hot_pend_q <= 1'b0;
            end else if (hot_req_i) begin
                hot_pend_q <= 1'b1;
            end
        end
    end

    // Registered reset outputs decoded from the next state
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            sticky_q_o <= 1'b1;
            core_q_o   <= 1'b1;
            stream_q_o <= 1'b1;
            csr_q_o    <= 1'b1;
            all_up_q_o <= 1'b0;
        end else begin
            sticky_q_o <= (state_d == SEQ_COLD);
            core_q_o   <= (state_d == SEQ_COLD) || (state_d == SEQ_CORE);
            stream_q_o <= (state_d != SEQ_RUN);
            csr_q_o    <= (state_d != SEQ_RUN);
            all_up_q_o <= (state_d == SEQ_RUN);
        end
    end

endmodule

// File: rtl/pcie_reset_ctrl.sv
`timescale 1ns/1ps
// Reset domain controller for a PCIe endpoint interface: synchronizes the
// platform reset, sequences the release of the sticky, core and bus
// domains, and spaces link resets with a guard window.
// Assumes: all inputs except plat_rst_n_i are synchronous to clk_i.
// Each output is forced high combinationally from the asynchronously
// cleared synchronizer, so assertion does not wait for an edge.
module pcie_reset_ctrl #(
    parameter int unsigned CLK_FREQ_HZ  = 200_000_000,
    parameter int unsigned GUARD_US     = 500,
    parameter int unsigned STAGE_CYCLES = 16,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk_i,
    input  logic plat_rst_n_i,
    input  logic warm_req_i,
    input  logic link_hot_rst_i,
    input  logic fn_rst_busy_i,
    output logic sticky_rst_o,
    output logic core_rst_o,
    output logic stream_rst_o,
    output logic csr_rst_o,
    output logic guard_active_o,
    output logic all_up_o
);

    localparam longint unsigned GUARD_64 =
        64'(CLK_FREQ_HZ) * 64'(GUARD_US) / 64'd1_000_000;
    localparam int unsigned GUARD_CYCLES = (GUARD_64 == 0) ? 1 : 32'(GUARD_64);

    logic rst_sync_n;
    logic guard_start, guard_active;
    logic sticky_q, core_q, stream_q, csr_q, all_up_q;

    rdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i     (clk_i),
        .async_n_i (plat_rst_n_i),
        .sync_n_o  (rst_sync_n)
    );

    rdc_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
        .clk_i    (clk_i),
        .rst_n_i  (rst_sync_n),
        .start_i  (guard_start),
        .active_o (guard_active)
    );

    rdc_sequencer #(.STAGE_CYCLES(STAGE_CYCLES)) u_seq (
        .clk_i          (clk_i),
        .rst_n_i        (rst_sync_n),
        .warm_req_i     (warm_req_i),
        .hot_req_i      (link_hot_rst_i),
        .fn_busy_i      (fn_rst_busy_i),
        .guard_active_i (guard_active),
        .sticky_q_o     (sticky_q),
        .core_q_o       (core_q),
        .stream_q_o     (stream_q),
        .csr_q_o        (csr_q),
        .all_up_q_o     (all_up_q),
        .release_o      (guard_start)
    );

    assign sticky_rst_o   = sticky_q | ~rst_sync_n;
    assign core_rst_o     = core_q   | ~rst_sync_n;
    assign stream_rst_o   = stream_q | ~rst_sync_n;
    assign csr_rst_o      = csr_q    | ~rst_sync_n;
    assign all_up_o       = all_up_q &  rst_sync_n;
    assign guard_active_o = guard_active;

endmodule

// File: rtl/pcie_reset_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for pcie_reset_ctrl, attached by bind below.
// Assumes: rst_sync_n is the controller's synchronized platform reset.
module pcie_reset_ctrl_chk (
    input logic clk_i,
    input logic rst_sync_n,
    input logic warm_req_i,
    input logic fn_rst_busy_i,
    input logic sticky_rst_o,
    input logic core_rst_o,
    input logic stream_rst_o,
    input logic csr_rst_o,
    input logic guard_active_o,
    input logic all_up_o
);

    a_r1_cold_asserts_all: assert property (@(posedge clk_i)
        !rst_sync_n |-> (sticky_rst_o && core_rst_o && stream_rst_o && csr_rst_o && !all_up_o));

    a_r3_sticky_nests_core: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        sticky_rst_o |-> core_rst_o);

    a_r3_core_nests_bus: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        core_rst_o |-> (stream_rst_o && csr_rst_o));

    a_r3_bus_pair_equal: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        stream_rst_o == csr_rst_o);

    a_r2_core_after_sticky: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        $fell(core_rst_o) |-> !sticky_rst_o && !$past(sticky_rst_o));

    a_r5_hot_gated: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        ($rose(core_rst_o) && !$past(warm_req_i)) |-> (!$past(guard_active_o) && !$past(fn_rst_busy_i)));

    a_r7_guard_on_release: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        $rose(guard_active_o) |-> $fell(stream_rst_o));

    a_r8_all_up_clean: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        all_up_o |-> !(sticky_rst_o || core_rst_o || stream_rst_o || csr_rst_o));

    a_r10_no_sticky_on_link: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        $rose(core_rst_o) |-> !sticky_rst_o);

endmodule

bind pcie_reset_ctrl pcie_reset_ctrl_chk u_chk (
    .clk_i          (clk_i),
    .rst_sync_n     (rst_sync_n),
    .warm_req_i     (warm_req_i),
    .fn_rst_busy_i  (fn_rst_busy_i),
    .sticky_rst_o   (sticky_rst_o),
    .core_rst_o     (core_rst_o),
    .stream_rst_o   (stream_rst_o),
    .csr_rst_o      (csr_rst_o),
    .guard_active_o (guard_active_o),
    .all_up_o       (all_up_o)
);

// File: tb/pcie_reset_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench for pcie_reset_ctrl: a table of warm/hot requests
// with guard and busy conditions, then directed reset and corner tests.
module pcie_reset_ctrl_test;

    localparam int FREQ = 200_000;
    localparam int GUS  = 500;
    localparam int S    = 4;
    localparam int G    = FREQ * GUS / 1_000_000;   // 100 cycles
    localparam int NV   = 7;
    // Table: op (0 warm, 1 hot), request inside the guard window, busy cycles
    localparam int T_OP   [NV] = '{1, 0, 1, 1, 0, 1, 0};
    localparam int T_GRD  [NV] = '{0, 1, 1, 0, 0, 1, 1};
    localparam int T_BUSY [NV] = '{0, 0, 0, 5, 7, 150, 0};

    logic clk = 1'b0;
    logic plat_rst_n = 1'b0, warm_req = 1'b0, hot_rst = 1'b0, fn_busy = 1'b0;
    logic sticky, core, stream, csr, guard, all_up;
    int   n_chk = 0, n_fail = 0, cyc = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    pcie_reset_ctrl #(.CLK_FREQ_HZ(FREQ), .GUARD_US(GUS), .STAGE_CYCLES(S)) uut (
        .clk_i(clk), .plat_rst_n_i(plat_rst_n), .warm_req_i(warm_req),
        .link_hot_rst_i(hot_rst), .fn_rst_busy_i(fn_busy),
        .sticky_rst_o(sticky), .core_rst_o(core), .stream_rst_o(stream),
        .csr_rst_o(csr), .guard_active_o(guard), .all_up_o(all_up));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    // Measure the release of a sequence already in its core stage
    task automatic measure_release(input string tag);
        int n = 0;
        bit pair_ok = 1'b1, sticky_ok = 1'b1;
        while (core) begin
            @(negedge clk); n++;
            if (stream != csr) pair_ok = 1'b0;
            if (sticky) sticky_ok = 1'b0;
        end
        check(n == S, {tag, " core hold"}, n, S);
        n = 0;
        while (stream) begin
            @(negedge clk); n++;
            if (stream != csr) pair_ok = 1'b0;
        end
        check(n == S, {tag, " bus hold"}, n, S);
        check(pair_ok, "R3 stream/csr equal", int'(pair_ok), 1);
        check(sticky_ok, "R10 sticky stays low", int'(sticky_ok), 1);
        check(all_up && guard, "R8 all_up after release", int'(all_up), 1);
    endtask

    // One table entry: starts at the negedge right after a release
    task automatic run_entry(input int op, input int in_grd, input int busy);
        int d = 0, exp;
        if (!in_grd) begin
            repeat (G + 2) @(negedge clk);
            check(!guard, "R7 guard closed", int'(guard), 0);
        end
        if (op == 0) warm_req = 1'b1; else hot_rst = 1'b1;
        fn_busy = (busy > 0);
        exp = (op == 0) ? 1 : (((in_grd ? G : 0) > busy ? (in_grd ? G : 0) : busy) + 1);
        do begin
            @(negedge clk); d++;
            warm_req = 1'b0; hot_rst = 1'b0;
            if (d >= busy) fn_busy = 1'b0;
        end while (!core && d < 1000);
        fn_busy = 1'b0;
        if (op == 0) check(d == exp, "R4 warm delay", d, exp);
        else if (busy > 0) check(d == exp, "R6 hot busy delay", d, exp);
        else if (in_grd) check(d == exp, "R5 hot guard delay", d, exp);
        else check(d == exp, "R10 hot idle delay", d, exp);
        check(!sticky && !all_up, "R10 sticky low during link reset", int'(sticky), 0);
        measure_release(op == 0 ? "R4" : "R10");
    endtask

    // Release the platform pin and check the staged order
    task automatic cold_release(input bit warm_mid);
        int n = 0;
        @(negedge clk); plat_rst_n = 1'b1;
        while (sticky && n < 100) begin @(negedge clk); n++; end
        check(core && stream, "R2 core held after sticky", int'(core), 1);
        if (warm_mid) warm_req = 1'b1;
        n = 0;
        while (core) begin @(negedge clk); n++; warm_req = 1'b0; end
        check(n == S, warm_mid ? "R9 core stage with warm" : "R2 core stage", n, S);
        n = 0;
        while (stream) begin
            @(negedge clk); n++;
            if (stream != csr) check(1'b0, "R3 pair", int'(stream), int'(csr));
        end
        check(n == S, warm_mid ? "R9 bus stage with warm" : "R2 bus stage", n, S);
    endtask

    initial begin
        // R1: reset state while the pin is low
        repeat (4) @(negedge clk);
        check(sticky && core && stream && csr, "R1 all asserted", int'(sticky & core & stream & csr), 1);
        check(!all_up, "R1 all_up low", int'(all_up), 0);
        check(!guard, "R1 guard closed", int'(guard), 0);

        cold_release(1'b0);
        begin
            int n = 0;
            while (guard) begin n++; @(negedge clk); end
            check(n == G, "R7 guard length", n, G);
            check(all_up, "R8 all_up high", int'(all_up), 1);
        end

        // Table of warm/hot requests
        for (int i = 0; i < NV; i++) begin
            run_entry(T_OP[i], T_GRD[i], T_BUSY[i]);
        end

        // R1: asynchronous assertion between clock edges
        @(posedge clk); #1 plat_rst_n = 1'b0;
        #1 check(sticky && core && stream && csr && !all_up, "R1 async assert",
                 int'(sticky & core & stream & csr), 1);

        // R9: warm request during a cold release is ignored
        repeat (3) @(negedge clk);
        cold_release(1'b1);
        check(all_up && !sticky, "R8 up after second cold", int'(all_up), 1);

        finish_run();
    end

endmodule